// File: doc/BRIEF.md
# Receive Idle Timeout Timer

This block measures how long a serial receiver's input has been idle since the last byte was written into its receive FIFO. The length is counted in character times. One character time, called the word time here, is the number of bit periods in one frame: start bit, data bits and stop bits. The timeout is a programmable whole number of word times. The block advances on a bit-period tick supplied by an external baud generator.

Every byte stored into the FIFO starts the count again from zero. When the programmed length has elapsed, the block can set a sticky timeout flag and pulse a receive-interrupt source strobe. It does so only if data is waiting in the FIFO, or if an override asks for timeout reporting on an empty FIFO. Software clears the flag by writing a one to bit 3 of the status register. The FIFO storage and the baud divider live outside this block.

Top module: `uart_rx_tmo`

## Requirements
- R1: While `tmo_en_i` is low, no timeout can occur. Dropping it cancels a running count, and only a later byte store arms the timer again.
- R2: The word time in ticks is `fmt_len_i + 5` data bits, plus 2 stop bits when `fmt_two_stop_i` is 1 (else 1), plus 1 start bit. This gives 7 to 11 ticks.
- R3: The timeout spans `tmo_mult_i` word times of `bit_tick_i` pulses after arming. The flag rises on the second clock edge after the edge that counts the last tick, and it is still low one cycle after the tick before the last.
- R4: A pulse on `byte_stored_i` clears the tick and word counts and arms the timer. Counts from before it are discarded.
- R5: Expiry sets the flag only when `data_ready_i` or `empty_ovr_i` is 1. An expiry without either is discarded, and the timer disarms.
- R6: A pulse on `trig_reached_i` cancels a pending timeout.
- R7: A cycle with `stat_wr_i` = 1 and `stat_wdata_i[3]` = 1 clears `tmo_flag_o`. A write with bit 3 at 0 leaves the flag unchanged. A set in the same cycle wins over a clear.
- R8: With `tmo_mult_i` = 0, the flag rises on the second edge after the edge that samples `byte_stored_i`, with no tick needed.
- R9: `rx_irq_o` is a one-cycle pulse that rises on the same edge as each setting of the flag. After reset, both outputs are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tmo_en_i | input | 1 | Timeout enable |
| tmo_mult_i | input | 4 | Timeout length in word times |
| empty_ovr_i | input | 1 | Allow timeout with empty FIFO |
| fmt_len_i | input | 2 | Data-bit code, data bits = code + 5 |
| fmt_two_stop_i | input | 1 | 1 selects two stop bits |
| bit_tick_i | input | 1 | One pulse per bit period |
| byte_stored_i | input | 1 | A received byte entered the FIFO |
| data_ready_i | input | 1 | FIFO holds data |
| trig_reached_i | input | 1 | FIFO reached its trigger level |
| stat_wr_i | input | 1 | Status register write strobe |
| stat_wdata_i | input | 8 | Status write data, bit 3 clears timeout |
| tmo_flag_o | output | 1 | Sticky timeout status |
| rx_irq_o | output | 1 | Receive interrupt source set pulse |

## Verification
The length check runs a set of format and multiplier combinations covering 7-, 8-, 10- and 11-tick word times and multipliers up to 15. Each one is probed one tick short of expiry and exactly at expiry, so a wrong word-time formula or a miscounted multiplier shows up as an early or late flag. Separate patterns re-arm the timer mid-count, cancel it through the enable and the trigger level, and expire it with and without data or the override. These tell a restart apart from an accumulation, and a discarded expiry apart from a reported one. Status writes with bit 3 set and clear separate the write-one-to-clear behaviour from any plain write.

// File: rtl/uart_tmo_pkg.sv
package uart_tmo_pkg;
  localparam int unsigned DATA_BASE = 5;
  localparam int unsigned WB_W      = 4;

  function automatic logic [WB_W-1:0] word_bits(input logic [1:0] len, input logic two_stop);
    return WB_W'(len) + WB_W'(DATA_BASE) + (two_stop ? WB_W'(2) : WB_W'(1)) + WB_W'(1);
  endfunction
endpackage

// File: rtl/uart_tmo_word_len.sv
module uart_tmo_word_len
  import uart_tmo_pkg::*;
(
  input  logic [1:0]      fmt_len_i,
  input  logic            fmt_two_stop_i,
  output logic [WB_W-1:0] word_bits_o
);
  assign word_bits_o = word_bits(fmt_len_i, fmt_two_stop_i);
endmodule

// File: rtl/uart_tmo_counter.sv
module uart_tmo_counter
  import uart_tmo_pkg::*;
#(
  parameter int unsigned MULT_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              run_i,
  input  logic              tick_i,
  input  logic [WB_W-1:0]   word_bits_i,
  output logic [MULT_W-1:0] words_o
);
  localparam logic [MULT_W-1:0] WORDS_MAX = '1;

  logic [WB_W-1:0]   bit_cnt_q;
  logic [MULT_W-1:0] word_cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_cnt_q  <= '0;
      word_cnt_q <= '0;
    end else if (clear_i) begin
      bit_cnt_q  <= '0;
      word_cnt_q <= '0;
    end else if (run_i && tick_i) begin
      if (bit_cnt_q >= word_bits_i - WB_W'(1)) begin
        bit_cnt_q <= '0;
        if (word_cnt_q != WORDS_MAX) word_cnt_q <= word_cnt_q + MULT_W'(1);
      end else begin
        bit_cnt_q <= bit_cnt_q + WB_W'(1);
      end
    end
  end

  assign words_o = word_cnt_q;
endmodule

// File: rtl/uart_tmo_flag.sv
module uart_tmo_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o,
  output logic pulse_o
);
  logic flag_q, pulse_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q  <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      pulse_q <= set_i;
      if (set_i)      flag_q <= 1'b1;  // set wins over clear
      else if (clr_i) flag_q <= 1'b0;
    end
  end

  assign flag_o  = flag_q;
  assign pulse_o = pulse_q;
endmodule

// File: rtl/uart_rx_tmo.sv
module uart_rx_tmo
  import uart_tmo_pkg::*;
#(
  parameter int unsigned MULT_W   = 4,
  parameter int unsigned STAT_W   = 8,
  parameter int unsigned FLAG_BIT = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tmo_en_i,
  input  logic [MULT_W-1:0] tmo_mult_i,
  input  logic              empty_ovr_i,
  input  logic [1:0]        fmt_len_i,
  input  logic              fmt_two_stop_i,
  input  logic              bit_tick_i,
  input  logic              byte_stored_i,
  input  logic              data_ready_i,
  input  logic              trig_reached_i,
  input  logic              stat_wr_i,
  input  logic [STAT_W-1:0] stat_wdata_i,
  output logic              tmo_flag_o,
  output logic              rx_irq_o
);
  logic [WB_W-1:0]   word_bits;
  logic [MULT_W-1:0] words;
  logic              armed_q, armed_d;
  logic              expire, report, clr;

  uart_tmo_word_len u_len (
    .fmt_len_i      (fmt_len_i),
    .fmt_two_stop_i (fmt_two_stop_i),
    .word_bits_o    (word_bits)
  );

  uart_tmo_counter #(.MULT_W(MULT_W)) u_cnt (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clear_i     (byte_stored_i | ~armed_q),
    .run_i       (armed_q),
    .tick_i      (bit_tick_i),
    .word_bits_i (word_bits),
    .words_o     (words)
  );

  assign expire = armed_q && tmo_en_i && !trig_reached_i && (words == tmo_mult_i);
  assign report = expire && (data_ready_i || empty_ovr_i);
  assign clr    = stat_wr_i && stat_wdata_i[FLAG_BIT];

  always_comb begin
    armed_d = armed_q;
    if (!tmo_en_i || trig_reached_i) armed_d = 1'b0;
    else if (byte_stored_i)          armed_d = 1'b1;
    else if (expire)                 armed_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed_q <= 1'b0;
    else         armed_q <= armed_d;
  end

  uart_tmo_flag u_flag (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .set_i   (report),
    .clr_i   (clr),
    .flag_o  (tmo_flag_o),
    .pulse_o (rx_irq_o)
  );
endmodule

// File: rtl/uart_rx_tmo_chk.sv
module uart_rx_tmo_chk #(
  parameter int unsigned STAT_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              tmo_en_i,
  input logic              empty_ovr_i,
  input logic              data_ready_i,
  input logic              trig_reached_i,
  input logic              stat_wr_i,
  input logic [STAT_W-1:0] stat_wdata_i,
  input logic              tmo_flag_o,
  input logic              rx_irq_o
);
  AST_NO_IRQ_WHEN_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_irq_o |-> $past(tmo_en_i)); // R1

  AST_IRQ_QUALIFIED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_irq_o |-> $past(data_ready_i || empty_ovr_i)); // R5

  AST_TRIG_CANCELS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_irq_o |-> !$past(trig_reached_i)); // R6

  AST_W1C_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(stat_wr_i && stat_wdata_i[3]) && !rx_irq_o) |-> !tmo_flag_o); // R7

  AST_IRQ_WITH_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tmo_flag_o) |-> rx_irq_o); // R9
endmodule

bind uart_rx_tmo uart_rx_tmo_chk #(.STAT_W(STAT_W)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .tmo_en_i       (tmo_en_i),
  .empty_ovr_i    (empty_ovr_i),
  .data_ready_i   (data_ready_i),
  .trig_reached_i (trig_reached_i),
  .stat_wr_i      (stat_wr_i),
  .stat_wdata_i   (stat_wdata_i),
  .tmo_flag_o     (tmo_flag_o),
  .rx_irq_o       (rx_irq_o)
);

// File: tb/uart_rx_tmo_test.sv
module uart_rx_tmo_test;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 6;
  // {mult[3:0], len[1:0], two_stop, pad, ticks[7:0]}
  localparam logic [15:0] VEC [NVEC] = '{
    {4'd1,  2'd0, 1'b0, 1'b0, 8'd7},
    {4'd2,  2'd3, 1'b1, 1'b0, 8'd22},
    {4'd3,  2'd1, 1'b0, 1'b0, 8'd24},
    {4'd15, 2'd2, 1'b1, 1'b0, 8'd150},
    {4'd4,  2'd3, 1'b0, 1'b0, 8'd40},
    {4'd5,  2'd0, 1'b1, 1'b0, 8'd40}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic en = 1'b1, ovr = 1'b0, two_stop = 1'b0, tick = 1'b0, byte_st = 1'b0;
  logic drdy = 1'b1, trig = 1'b0, swr = 1'b0;
  logic [3:0] mult = 4'd1;
  logic [1:0] len = 2'd0;
  logic [7:0] swd = 8'd0;
  logic flag, irq;
  int errors = 0, checks = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_rx_tmo uut (
    .clk_i(clk), .rst_ni(rst_n), .tmo_en_i(en), .tmo_mult_i(mult), .empty_ovr_i(ovr),
    .fmt_len_i(len), .fmt_two_stop_i(two_stop), .bit_tick_i(tick), .byte_stored_i(byte_st),
    .data_ready_i(drdy), .trig_reached_i(trig), .stat_wr_i(swr), .stat_wdata_i(swd),
    .tmo_flag_o(flag), .rx_irq_o(irq)
  );

  task automatic check(input logic act, input logic exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tick = 1'b1; cyc(1); tick = 1'b0;
    end
  endtask

  task automatic arm();
    byte_st = 1'b1; cyc(1); byte_st = 1'b0;
  endtask

  task automatic wstat(input logic [7:0] v);
    swr = 1'b1; swd = v; cyc(1); swr = 1'b0; swd = 8'd0;
  endtask

  initial begin
    cyc(2);
    check(flag, 1'b0, "R9 reset flag");
    check(irq, 1'b0, "R9 reset irq");
    rst_n = 1'b1;
    cyc(1);

    // table walk: R2 word time, R3 length
    for (int v = 0; v < NVEC; v++) begin
      mult = VEC[v][15:12]; len = VEC[v][11:10]; two_stop = VEC[v][9];
      wstat(8'h08);
      arm();
      ticks(int'(VEC[v][7:0]) - 1);
      cyc(1);
      check(flag, 1'b0, $sformatf("R3 early vec%0d", v));
      ticks(1);
      cyc(1);
      check(flag, 1'b1, $sformatf("R2 R3 expiry vec%0d", v));
      check(irq, 1'b1, $sformatf("R9 irq vec%0d", v));
    end
    cyc(1);
    check(irq, 1'b0, "R9 irq single pulse");
    check(flag, 1'b1, "R9 flag sticky");

    // R7 write-one-to-clear
    wstat(8'hF7);
    check(flag, 1'b1, "R7 bit3 zero no clear");
    wstat(8'h08);
    check(flag, 1'b0, "R7 bit3 clears");

    mult = 4'd1; len = 2'd0; two_stop = 1'b0;
    // R1 disabled
    en = 1'b0; arm(); ticks(10); cyc(1);
    check(flag, 1'b0, "R1 disabled no timeout");
    en = 1'b1; arm(); ticks(3); en = 1'b0; cyc(1); en = 1'b1; ticks(10); cyc(1);
    check(flag, 1'b0, "R1 cancel by disable");

    // R4 restart
    arm(); ticks(5); arm(); ticks(6); cyc(1);
    check(flag, 1'b0, "R4 restart not accumulated");
    ticks(1); cyc(1);
    check(flag, 1'b1, "R4 expiry after restart");
    wstat(8'h08);

    // R5 qualification
    drdy = 1'b0; ovr = 1'b0;
    arm(); ticks(7); cyc(1);
    check(flag, 1'b0, "R5 unqualified no flag");
    check(irq, 1'b0, "R5 unqualified no irq");
    drdy = 1'b1; ticks(10); cyc(1);
    check(flag, 1'b0, "R5 disarmed after discard");
    drdy = 1'b0; ovr = 1'b1;
    arm(); ticks(7); cyc(1);
    check(flag, 1'b1, "R5 override reports");
    drdy = 1'b1; ovr = 1'b0;
    wstat(8'h08);

    // R6 trigger cancel
    arm(); ticks(3); trig = 1'b1; cyc(1); trig = 1'b0; ticks(10); cyc(1);
    check(flag, 1'b0, "R6 trigger cancels");

    // R8 zero multiplier
    mult = 4'd0;
    arm();
    check(flag, 1'b0, "R8 not yet set");
    cyc(1);
    check(flag, 1'b1, "R8 zero mult expiry");
    check(irq, 1'b1, "R8 irq");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule